// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block connects a simple request port to an asynchronous DRAM with a 16-bit data bus. It works with fast-page-mode and EDO parts. A master presents an address, a write flag, two byte enables and write data, holding `req_valid` high. The controller runs one DRAM cycle and answers with a single-cycle `req_ready` pulse. For reads, `req_rdata` carries the data in that same cycle. The halfword address splits into a row field in the upper bits and a column field in the lower bits. Both fields go out over one multiplexed address bus.

After an access the row stays open, with RAS held low. A later request to the same row skips precharge and row activation and runs a short page cycle. A request to any other row first closes the row for a fixed precharge time, then opens the new one.

A free-running interval timer posts refresh requests. A refresh request is served at the next idle point, ahead of any waiting access. It runs a CAS-before-RAS cycle, and that cycle leaves no row open. All timings are parameters fixed at elaboration. The `cfg_edo` pin selects when read data is captured.

Top module: `dram_page_ctrl`

## Requirements
- R1: While reset is held, `mem_ras_n`, `mem_ucas_n`, `mem_lcas_n` and `mem_we_n` are high, and `mem_dq_oe` and `req_ready` are low.
- R2: A request is taken when `req_valid` is high, the controller is idle and `req_ready` is low. Each taken request produces exactly one `req_ready` pulse, one cycle wide.
- R3: A row miss first holds RAS high for at least PRE_CYC cycles with the row address on `mem_addr`. It then drops RAS, then drives the column and drops CAS. `req_ready` rises PRE_CYC+CAS_CYC+3 clock edges after the edge that takes the request, counting that edge.
- R4: A request whose row equals the open row skips precharge and activation. `req_ready` rises CAS_CYC+2 edges after the accepting edge, counting that edge.
- R5: `req_be[0]` enables the lower CAS (`mem_lcas_n`, data bits 7:0) and `req_be[1]` enables the upper CAS (`mem_ucas_n`, data bits 15:8). A write changes only the enabled bytes.
- R6: With `cfg_edo` low, read data is captured on the last edge at which CAS is still low.
- R7: With `cfg_edo` high, read data is captured on the edge one cycle after CAS rises.
- R8: A refresh request is raised every REF_INT cycles. A pending refresh wins over a waiting access at the idle point and closes the open row, so the next access to that row is a miss.
- R9: A refresh drives both CAS lines low at least one cycle before RAS falls. It releases both one cycle after RAS rises. CAS low while RAS is high occurs only in this cycle, and always on both lines.
- R10: While CAS stays low across consecutive cycles, `mem_addr` and `mem_we_n` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_edo | input | 1 | 1 selects EDO read capture, 0 fast-page capture |
| req_valid | input | 1 | Request present, held until `req_ready` |
| req_we | input | 1 | 1 write, 0 read |
| req_be | input | 2 | Byte enables, bit 0 low byte, bit 1 high byte |
| req_addr | input | ROW_W+COL_W | Halfword address, row in upper bits |
| req_wdata | input | 2*LANE_W | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 2*LANE_W | Read data, valid with `req_ready` |
| mem_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_ucas_n | output | 1 | Upper-byte column strobe, active low |
| mem_lcas_n | output | 1 | Lower-byte column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_dq_out | output | 2*LANE_W | Data driven to the DRAM |
| mem_dq_oe | output | 1 | Output enable for `mem_dq_out` |
| mem_dq_in | input | 2*LANE_W | Data returned by the DRAM |

## Verification
The assertions check the strobe discipline on every cycle: single-cycle ready pulses, the minimum RAS-high time before any RAS fall, CAS-before-RAS ordering and release, CAS never low alone while RAS is high, and a stable address and write strobe under CAS. The bench scenarios are the only way to show the rest. These are hit and miss latencies, byte-lane write merging, which edge captures read data in each mode, the refresh period, and the row being closed after a refresh. For the capture checks, the bench's DRAM model returns distinct filler values outside the valid data window.

// File: rtl/dram_pkg.sv
package dram_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ROW,
        ST_COL,
        ST_CASUP,
        ST_CBR_CAS,
        ST_CBR_RAS,
        ST_CBR_RUP
    } dram_state_e;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
    parameter int INTERVAL = 256
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = $clog2(INTERVAL);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(INTERVAL - 1));
        cnt_d = tick ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/dram_row_match.sv
module dram_row_match #(
    parameter int ROW_W = 9
) (
    input  logic             row_open,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             hit
);
    assign hit = row_open && (open_row == req_row);
endmodule

// File: rtl/dram_lane_map.sv
module dram_lane_map #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] be,
    output logic [LANES-1:0] cas_n
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign cas_n[i] = ~be[i];
    end
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
    import dram_pkg::*;
#(
    parameter int ROW_W   = 9,
    parameter int COL_W   = 8,
    parameter int LANE_W  = 8,
    parameter int PRE_CYC = 2,
    parameter int CAS_CYC = 2,
    parameter int RAS_CYC = 3,
    parameter int REF_INT = 256,
    localparam int DATA_W = 2 * LANE_W,
    localparam int AW     = ROW_W + COL_W,
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_edo,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_be,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [MA_W-1:0]   mem_addr,
    output logic              mem_ras_n,
    output logic              mem_ucas_n,
    output logic              mem_lcas_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    input  logic [DATA_W-1:0] mem_dq_in
);
    localparam int MAXC  = (PRE_CYC > CAS_CYC) ? ((PRE_CYC > RAS_CYC) ? PRE_CYC : RAS_CYC)
                                               : ((CAS_CYC > RAS_CYC) ? CAS_CYC : RAS_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);

    typedef struct packed {
        dram_state_e       state;
        logic [CNT_W-1:0]  cnt;
        logic              for_ref;
        logic              ref_pend;
        logic              row_open;
        logic [ROW_W-1:0]  open_row;
        logic [ROW_W-1:0]  lat_row;
        logic [COL_W-1:0]  lat_col;
        logic              lat_we;
        logic              lat_edo;
        logic [1:0]        lat_cas_n;
        logic              ras_n;
        logic              ucas_n;
        logic              lcas_n;
        logic              we_n;
        logic [MA_W-1:0]   addr;
        logic              dq_oe;
        logic [DATA_W-1:0] dq_out;
        logic              ready;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t d, q;

    logic             ref_tick;
    logic             page_hit;
    logic [1:0]       sel_cas_n;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;

    assign req_row = req_addr[AW-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    dram_refresh_timer #(.INTERVAL(REF_INT)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (ref_tick)
    );

    dram_row_match #(.ROW_W(ROW_W)) u_match (
        .row_open(q.row_open),
        .open_row(q.open_row),
        .req_row (req_row),
        .hit     (page_hit)
    );

    dram_lane_map #(.LANES(2)) u_lanes (
        .be   (req_be),
        .cas_n(sel_cas_n)
    );

    always_comb begin
        d          = q;
        d.ready    = 1'b0;
        d.ref_pend = q.ref_pend | ref_tick;
        case (q.state)
            ST_IDLE: begin
                if (q.ref_pend) begin
                    d.ref_pend = ref_tick;
                    d.for_ref  = 1'b1;
                    d.row_open = 1'b0;
                    d.ras_n    = 1'b1;
                    d.cnt      = CNT_W'(PRE_CYC - 1);
                    d.state    = ST_PRE;
                end else if (req_valid && !q.ready) begin
                    d.lat_row   = req_row;
                    d.lat_col   = req_col;
                    d.lat_we    = req_we;
                    d.lat_edo   = cfg_edo;
                    d.lat_cas_n = sel_cas_n;
                    d.dq_out    = req_wdata;
                    if (page_hit) begin
                        d.addr   = MA_W'(req_col);
                        d.ucas_n = sel_cas_n[1];
                        d.lcas_n = sel_cas_n[0];
                        d.we_n   = ~req_we;
                        d.dq_oe  = req_we;
                        d.cnt    = CNT_W'(CAS_CYC - 1);
                        d.state  = ST_COL;
                    end else begin
                        d.for_ref  = 1'b0;
                        d.row_open = 1'b0;
                        d.ras_n    = 1'b1;
                        d.addr     = MA_W'(req_row);
                        d.cnt      = CNT_W'(PRE_CYC - 1);
                        d.state    = ST_PRE;
                    end
                end
            end
            ST_PRE: begin
                if (q.cnt == '0) begin
                    if (q.for_ref) begin
                        d.ucas_n = 1'b0;
                        d.lcas_n = 1'b0;
                        d.state  = ST_CBR_CAS;
                    end else begin
                        d.ras_n    = 1'b0;
                        d.row_open = 1'b1;
                        d.open_row = q.lat_row;
                        d.state    = ST_ROW;
                    end
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_ROW: begin
                d.addr   = MA_W'(q.lat_col);
                d.ucas_n = q.lat_cas_n[1];
                d.lcas_n = q.lat_cas_n[0];
                d.we_n   = ~q.lat_we;
                d.dq_oe  = q.lat_we;
                d.cnt    = CNT_W'(CAS_CYC - 1);
                d.state  = ST_COL;
            end
            ST_COL: begin
                if (q.cnt == '0) begin
                    d.ucas_n = 1'b1;
                    d.lcas_n = 1'b1;
                    d.we_n   = 1'b1;
                    d.dq_oe  = 1'b0;
                    if (!q.lat_edo && !q.lat_we) d.rdata = mem_dq_in;
                    d.state = ST_CASUP;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CASUP: begin
                if (q.lat_edo && !q.lat_we) d.rdata = mem_dq_in;
                d.ready = 1'b1;
                d.state = ST_IDLE;
            end
            ST_CBR_CAS: begin
                d.ras_n = 1'b0;
                d.cnt   = CNT_W'(RAS_CYC - 1);
                d.state = ST_CBR_RAS;
            end
            ST_CBR_RAS: begin
                if (q.cnt == '0) begin
                    d.ras_n = 1'b1;
                    d.state = ST_CBR_RUP;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_CBR_RUP: begin
                d.ucas_n = 1'b1;
                d.lcas_n = 1'b1;
                d.state  = ST_IDLE;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.state  <= ST_IDLE;
            q.ras_n  <= 1'b1;
            q.ucas_n <= 1'b1;
            q.lcas_n <= 1'b1;
            q.we_n   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign req_ready  = q.ready;
    assign req_rdata  = q.rdata;
    assign mem_addr   = q.addr;
    assign mem_ras_n  = q.ras_n;
    assign mem_ucas_n = q.ucas_n;
    assign mem_lcas_n = q.lcas_n;
    assign mem_we_n   = q.we_n;
    assign mem_dq_out = q.dq_out;
    assign mem_dq_oe  = q.dq_oe;
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk #(
    parameter int PRE_CYC = 2,
    parameter int MA_W    = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_ready,
    input logic [MA_W-1:0] mem_addr,
    input logic            mem_ras_n,
    input logic            mem_ucas_n,
    input logic            mem_lcas_n,
    input logic            mem_we_n
);
    logic [7:0] ras_hi_cnt;
    logic       cas_any;

    assign cas_any = !mem_ucas_n || !mem_lcas_n;

    always_ff @(posedge clk) begin
        if (!rst_n)                 ras_hi_cnt <= '0;
        else if (!mem_ras_n)        ras_hi_cnt <= '0;
        else if (ras_hi_cnt != 8'hFF) ras_hi_cnt <= ras_hi_cnt + 1'b1;
    end

    AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |=> !req_ready); // R2

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_ras_n) |-> (ras_hi_cnt >= 8'(PRE_CYC))); // R3

    AST_CBR_CAS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(mem_ras_n) && cas_any) |-> $past(!mem_ucas_n && !mem_lcas_n)); // R9

    AST_CBR_CAS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_ras_n) && cas_any) |=> (mem_ucas_n && mem_lcas_n)); // R9

    AST_CAS_PAIR_RAS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_ras_n && cas_any) |-> (!mem_ucas_n && !mem_lcas_n)); // R9

    AST_ADDR_STABLE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_any && $past(cas_any)) |-> ($stable(mem_addr) && $stable(mem_we_n))); // R10
endmodule

bind dram_page_ctrl dram_page_ctrl_chk #(.PRE_CYC(PRE_CYC), .MA_W(MA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_addr  (mem_addr),
    .mem_ras_n (mem_ras_n),
    .mem_ucas_n(mem_ucas_n),
    .mem_lcas_n(mem_lcas_n),
    .mem_we_n  (mem_we_n)
);

// File: tb/dram_page_ctrl_test.sv
module dram_page_ctrl_test;
    localparam int ROW_W = 9, COL_W = 8, LANE_W = 8;
    localparam int PRE = 2, CASC = 2, REF = 300;
    localparam int LAT_MISS = PRE + CASC + 3;
    localparam int LAT_HIT  = CASC + 2;

    typedef struct packed {
        logic        we;
        logic [1:0]  be;
        logic [8:0]  row;
        logic [7:0]  col;
        logic [15:0] data;
        logic [3:0]  lat;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{1'b1, 2'b11, 9'd5,    8'd3,    16'hA1B2, 4'd7},
        '{1'b0, 2'b11, 9'd5,    8'd3,    16'h0000, 4'd4},
        '{1'b1, 2'b01, 9'd5,    8'd4,    16'h33CC, 4'd4},
        '{1'b0, 2'b11, 9'd5,    8'd4,    16'h0000, 4'd4},
        '{1'b1, 2'b10, 9'd5,    8'd4,    16'h77EE, 4'd4},
        '{1'b0, 2'b11, 9'd5,    8'd4,    16'h0000, 4'd4},
        '{1'b0, 2'b11, 9'd2,    8'd9,    16'h0000, 4'd7},
        '{1'b1, 2'b11, 9'd2,    8'd9,    16'h5A5A, 4'd4},
        '{1'b0, 2'b11, 9'd5,    8'd3,    16'h0000, 4'd7},
        '{1'b0, 2'b11, 9'd2,    8'd9,    16'h0000, 4'd7},
        '{1'b1, 2'b11, 9'h1F5,  8'hF3,   16'h0F0F, 4'd7},
        '{1'b0, 2'b11, 9'd5,    8'd3,    16'h0000, 4'd7}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_edo = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_be = 2'b00;
    logic [16:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic [15:0] req_rdata;
    logic [8:0]  mem_addr;
    logic        mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n, mem_dq_oe;
    logic [15:0] mem_dq_out, mem_dq_in;

    always #2 clk = ~clk;

    dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .LANE_W(LANE_W), .PRE_CYC(PRE),
                     .CAS_CYC(CASC), .RAS_CYC(3), .REF_INT(REF)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_edo(cfg_edo), .req_valid(req_valid),
        .req_we(req_we), .req_be(req_be), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .mem_addr(mem_addr),
        .mem_ras_n(mem_ras_n), .mem_ucas_n(mem_ucas_n), .mem_lcas_n(mem_lcas_n),
        .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
        .mem_dq_in(mem_dq_in)
    );

    // DRAM model: fast-page data only while CAS is low, EDO data only after CAS rises
    logic [15:0] mem [256];
    logic [15:0] ref_mem [256];
    logic [3:0]  m_row = '0, m_col = '0;
    logic [15:0] m_hold = '0;
    logic        tb_edo = 1'b0;
    logic        p_ras = 1'b1, p_u = 1'b1, p_l = 1'b1, p_we = 1'b1;
    logic [8:0]  p_addr = '0;
    logic        cbr_active = 1'b0, rel_pend = 1'b0;
    int          cbr_events = 0, cbr_bad = 0, addr_bad = 0, ready_pulses = 0;
    int          cyc = 0, last_cbr = 0, cbr_period = 0;
    int          checks = 0, errors = 0, reqs = 0;
    logic        cas_low;

    assign cas_low   = !mem_ucas_n || !mem_lcas_n;
    assign mem_dq_in = tb_edo ? (cas_low ? 16'hBEEF : m_hold)
                              : (cas_low ? mem[{m_row, m_col}] : 16'hDEAD);

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = 16'(i * 16'h0101) ^ 16'h5A00;
            ref_mem[i] = 16'(i * 16'h0101) ^ 16'h5A00;
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (req_ready) ready_pulses <= ready_pulses + 1;
            if (p_ras && !mem_ras_n && !cas_low) m_row <= mem_addr[3:0];
            if (p_u && p_l && cas_low && !mem_ras_n) begin
                m_col  <= mem_addr[3:0];
                m_hold <= mem[{m_row, mem_addr[3:0]}];
                if (!mem_we_n) begin
                    if (!mem_lcas_n) mem[{m_row, mem_addr[3:0]}][7:0]  <= mem_dq_out[7:0];
                    if (!mem_ucas_n) mem[{m_row, mem_addr[3:0]}][15:8] <= mem_dq_out[15:8];
                end
            end
            if (p_u && p_l && cas_low && mem_ras_n) begin
                cbr_events <= cbr_events + 1;
                cbr_period <= cyc - last_cbr;
                last_cbr   <= cyc;
                cbr_active <= 1'b1;
                if (mem_ucas_n || mem_lcas_n) cbr_bad <= cbr_bad + 1;
            end
            if (cbr_active && !p_ras && !cas_low && !mem_ras_n) cbr_bad <= cbr_bad + 1;
            if (cbr_active && !p_ras && mem_ras_n) rel_pend <= 1'b1;
            if (rel_pend) begin
                rel_pend   <= 1'b0;
                cbr_active <= 1'b0;
                if (cas_low) cbr_bad <= cbr_bad + 1;
            end
            if (cas_low && !(p_u && p_l) && (mem_addr != p_addr || mem_we_n != p_we))
                addr_bad <= addr_bad + 1;
        end
        p_ras <= mem_ras_n; p_u <= mem_ucas_n; p_l <= mem_lcas_n;
        p_addr <= mem_addr; p_we <= mem_we_n;
    end

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic access(input logic we, input logic [1:0] be, input logic [8:0] row,
                          input logic [7:0] col, input logic [15:0] data,
                          output int lat, output logic [15:0] rd);
        @(negedge clk);
        req_valid = 1'b1; req_we = we; req_be = be;
        req_addr = {row, col}; req_wdata = data;
        reqs++;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!req_ready && lat < 40);
        rd = req_rdata;
        req_valid = 1'b0;
        if (we) begin
            if (be[0]) ref_mem[{row[3:0], col[3:0]}][7:0]  = data[7:0];
            if (be[1]) ref_mem[{row[3:0], col[3:0]}][15:8] = data[15:8];
        end
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        checks++; errors++;
        $display("FAIL watchdog actual %0h expected %0h", 0, 1);
        finish_run();
    end

    initial begin
        int lat, c0, start;
        logic [15:0] rd;
        repeat (4) @(negedge clk);
        // R1 reset state
        check(mem_ras_n && mem_ucas_n && mem_lcas_n && mem_we_n, "R1", "strobes in reset",
              {mem_ras_n, mem_ucas_n, mem_lcas_n, mem_we_n}, 4'hF);
        check(!mem_dq_oe && !req_ready, "R1", "oe/ready in reset", {mem_dq_oe, req_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk, fast-page mode: R3/R4 latency, R5 lanes, R6 capture
        for (int i = 0; i < 12; i++) begin
            c0 = cbr_events;
            access(VECS[i].we, VECS[i].be, VECS[i].row, VECS[i].col, VECS[i].data, lat, rd);
            if (c0 == cbr_events)
                check(lat == int'(VECS[i].lat), (VECS[i].lat == 4'd7) ? "R3" : "R4",
                      "latency", lat, VECS[i].lat);
            if (!VECS[i].we)
                check(rd == ref_mem[{VECS[i].row[3:0], VECS[i].col[3:0]}],
                      (i == 3 || i == 5) ? "R5" : "R6", "read data", rd,
                      ref_mem[{VECS[i].row[3:0], VECS[i].col[3:0]}]);
        end

        // R8 refresh period while idle
        start = cbr_events;
        while (cbr_events < start + 2 && cyc < 5000) @(negedge clk);
        check(cbr_period == REF, "R8", "refresh period", cbr_period, REF);
        check(cbr_bad == 0, "R9", "CBR strobe order", cbr_bad, 0);

        // R8 refresh closes the open row
        access(1'b0, 2'b11, 9'd7, 8'd1, 16'h0, lat, rd);
        access(1'b0, 2'b11, 9'd7, 8'd1, 16'h0, lat, rd);
        check(lat == LAT_HIT, "R4", "hit before refresh", lat, LAT_HIT);
        start = cbr_events;
        while (cbr_events == start && cyc < 8000) @(negedge clk);
        repeat (10) @(negedge clk);
        access(1'b0, 2'b11, 9'd7, 8'd1, 16'h0, lat, rd);
        check(lat == LAT_MISS, "R8", "miss after refresh", lat, LAT_MISS);

        // R7 EDO capture after CAS rises
        cfg_edo = 1'b1; tb_edo = 1'b1;
        access(1'b1, 2'b11, 9'd7, 8'd2, 16'hC3D4, lat, rd);
        access(1'b0, 2'b11, 9'd7, 8'd2, 16'h0, lat, rd);
        check(rd == 16'hC3D4, "R7", "EDO read data", rd, 16'hC3D4);
        check(lat == LAT_HIT, "R7", "EDO hit latency", lat, LAT_HIT);
        access(1'b0, 2'b10, 9'd7, 8'd1, 16'h0, lat, rd);
        check(rd[15:8] == ref_mem[{4'd7, 4'd1}][15:8], "R5", "upper lane read", rd[15:8],
              ref_mem[{4'd7, 4'd1}][15:8]);
        cfg_edo = 1'b0; tb_edo = 1'b0;

        repeat (4) @(negedge clk);
        check(ready_pulses == reqs, "R2", "ready pulses", ready_pulses, reqs);
        check(addr_bad == 0, "R10", "address under CAS", addr_bad, 0);
        check(cbr_bad == 0, "R9", "CBR strobe order final", cbr_bad, 0);
        finish_run();
    end
endmodule